// File: doc/BRIEF.md
# Dual Real-Time-Clock Alarm Comparator

This block keeps two independent alarm settings next to a real-time clock and compares each of them, once per one-second tick, against the BCD calendar time supplied by the clock counters (month, date, hour, minute, second). Each alarm has a five-bit repeat code. The code chooses which calendar fields must agree before the alarm fires. When an alarm fires, its flag bit is set. If that alarm's interrupt enable is also set, the active-low interrupt line is pulled low.

A host reaches the alarm settings and the flag register through a small register port. A pointer-load strobe sets an address pointer. Each accepted read or write uses the current pointer and then advances it by one. Pointer position matters for the interrupt: while the pointer rests on the flag register, the interrupt line is held inactive. A read of the flag register returns the flags and clears them. While the supply runs from the backup battery, the host port is shut off, but alarm matching and the interrupt line keep working.

Top module: `rtc_alarm_pair`

## Requirements
- R1: After reset all alarm registers and both flags read 0x00 and `irq_n` is high.
- R2: Alarm A is at addresses 0x0A..0x0E and alarm B at 0x14..0x18. The five bytes of an alarm are, in order: byte 0 = {irq enable in bit 7, month in bits 6:0}; byte 1 = {repeat bit 5 in bit 7, repeat bit 4 in bit 6, date in bits 5:0}; byte 2 = {repeat bit 3 in bit 7, hour in bits 6:0}; byte 3 = {repeat bit 2 in bit 7, minute in bits 6:0}; byte 4 = {repeat bit 1 in bit 7, second in bits 6:0}. A write stores its byte, and a read returns it in `rdata` on the cycle after `rd_en`. Every accepted read or write advances the pointer by one. Unimplemented addresses read 0x00.
- R3: The pointer wraps from 0x18 to 0x00 after an access.
- R4: The repeat code is written as bits 5..1. Code 11111 fires on every tick. Code 11110 needs the second to match. Code 11100 adds the minute. Code 11000 adds the hour. Code 10000 adds the date. Code 00000 adds the month.
- R5: Any repeat code not listed in R4 fires on every tick.
- R6: Matching is evaluated only in a cycle where `sec_tick` is high.
- R7: The flag register is at 0x0F, with alarm A's flag in bit 0 and alarm B's flag in bit 1. A firing alarm sets its flag whether or not its interrupt is enabled. `irq_n` is low exactly when some flag is set, that alarm's enable is set, and the pointer is not 0x0F.
- R8: A read of 0x0F returns the flags as they stood before the read and clears them, which releases `irq_n`. A second read returns 0x00.
- R9: An alarm whose date field and all five repeat bits are zero never fires.
- R10: While `on_batt` is high, pointer loads, reads and writes are ignored, but alarms still fire and `irq_n` still responds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse per elapsed second |
| on_batt | input | 1 | High while the supply runs from the backup battery |
| cur_mon | input | 8 | Current month, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_min | input | 8 | Current minute, BCD |
| cur_sec | input | 8 | Current second, BCD |
| ptr_ld | input | 1 | Load the address pointer from `ptr_val` |
| ptr_val | input | 5 | New pointer value |
| wr_en | input | 1 | Write `wdata` at the pointer, then advance it |
| rd_en | input | 1 | Read at the pointer, then advance it |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
A pointer that drifts from its true value shows up on the next read, because `rdata` comes from the wrong byte. It also shows up on `irq_n`, which becomes wrongly masked or unmasked. A decoded repeat mask that is off shows up as a flag that appears, or is missing, one cycle after the tick in question. A flag that fails to clear keeps `irq_n` low right after the flag read, and the following read of 0x0F returns it. The bench reads every register of interest back over the port. It checks `irq_n` one cycle after each tick or pointer move.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int NFIELD = 5;

  typedef logic [NFIELD-1:0] rpt_t;

  // Field enable mask, bit order {month, date, hour, minute, second}.
  function automatic logic [NFIELD-1:0] rpt_to_mask(input rpt_t code);
    logic [NFIELD-1:0] m;
    case (code)
      5'b11111: m = 5'b00000;
      5'b11110: m = 5'b00001;
      5'b11100: m = 5'b00011;
      5'b11000: m = 5'b00111;
      5'b10000: m = 5'b01111;
      5'b00000: m = 5'b11111;
      default:  m = 5'b00000;
    endcase
    return m;
  endfunction

  // Every enabled field must compare equal.
  function automatic logic fields_agree(input logic [NFIELD-1:0] mask,
                                        input logic [NFIELD-1:0] eq);
    return &(eq | ~mask);
  endfunction

endpackage

// File: rtl/rtc_alarm_ptr.sv
module rtc_alarm_ptr #(
  parameter int ADDR_W   = 5,
  parameter int TOP_ADDR = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  localparam logic [ADDR_W-1:0] TOP = ADDR_W'(TOP_ADDR);

  logic [ADDR_W-1:0] ptr_nx;

  always_comb begin
    ptr_nx = ptr;
    if (load)      ptr_nx = (load_val > TOP) ? '0 : load_val;
    else if (step) ptr_nx = (ptr == TOP) ? '0 : ptr + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nx;
  end
endmodule

// File: rtl/rtc_alarm_slot.sv
module rtc_alarm_slot
  import rtc_alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DW     = 8,
  parameter int BASE   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [DW-1:0]     wdata,
  input  logic              tick,
  input  logic [DW-1:0]     cur_mon,
  input  logic [DW-1:0]     cur_date,
  input  logic [DW-1:0]     cur_hour,
  input  logic [DW-1:0]     cur_min,
  input  logic [DW-1:0]     cur_sec,
  output logic              hit,
  output logic [DW-1:0]     rd_val,
  output logic              irq_en,
  output logic              fire
);
  localparam int NREG  = NFIELD;
  localparam int OFF_W = $clog2(NREG);

  logic [DW-1:0]    regs [NREG];
  logic [OFF_W-1:0] off;
  rpt_t             code;
  logic [NFIELD-1:0] eq;
  logic             disabled;

  assign hit = (int'(ptr) >= BASE) && (int'(ptr) < BASE + NREG);
  assign off = OFF_W'(int'(ptr) - BASE);

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  regs[g] <= '0;
      else if (wr_go && hit && off == OFF_W'(g))   regs[g] <= wdata;
    end
  end

  assign rd_val = hit ? regs[off] : '0;
  assign irq_en = regs[0][7];
  assign code   = {regs[1][7], regs[1][6], regs[2][7], regs[3][7], regs[4][7]};

  assign eq = {cur_mon  == {1'b0, regs[0][6:0]},
               cur_date == {2'b0, regs[1][5:0]},
               cur_hour == {1'b0, regs[2][6:0]},
               cur_min  == {1'b0, regs[3][6:0]},
               cur_sec  == {1'b0, regs[4][6:0]}};

  assign disabled = (code == '0) && (regs[1][5:0] == '0);
  assign fire     = tick && !disabled && fields_agree(rpt_to_mask(code), eq);
endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags #(
  parameter int NAL = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NAL-1:0] fire,
  input  logic           clr,
  input  logic [NAL-1:0] enables,
  input  logic           masked,
  output logic [NAL-1:0] flags,
  output logic           irq_n
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (clr ? '0 : flags) | fire;
  end

  assign irq_n = !((|(flags & enables)) && !masked);
endmodule

// File: rtl/rtc_alarm_pair.sv
module rtc_alarm_pair #(
  parameter int ADDR_W    = 5,
  parameter int DW        = 8,
  parameter int A_BASE    = 10,
  parameter int B_BASE    = 20,
  parameter int FLAG_ADDR = 15,
  parameter int TOP_ADDR  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              on_batt,
  input  logic [DW-1:0]     cur_mon,
  input  logic [DW-1:0]     cur_date,
  input  logic [DW-1:0]     cur_hour,
  input  logic [DW-1:0]     cur_min,
  input  logic [DW-1:0]     cur_sec,
  input  logic              ptr_ld,
  input  logic [ADDR_W-1:0] ptr_val,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq_n
);
  localparam int NAL = 2;
  localparam logic [ADDR_W-1:0] FLAG = ADDR_W'(FLAG_ADDR);

  logic              bus_ok, wr_go, rd_go, ld_go;
  logic [ADDR_W-1:0] ptr_q;
  logic [NAL-1:0]    fire_ev, hit_v, en_v, flags_q;
  logic [DW-1:0]     slot_rd [NAL];
  logic              flag_rd_ev, on_flag;
  logic [DW-1:0]     rd_mux;

  assign bus_ok = !on_batt;
  assign wr_go  = wr_en  && bus_ok;
  assign rd_go  = rd_en  && bus_ok;
  assign ld_go  = ptr_ld && bus_ok;

  rtc_alarm_ptr #(.ADDR_W(ADDR_W), .TOP_ADDR(TOP_ADDR)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ld_go), .load_val(ptr_val),
    .step(wr_go || rd_go), .ptr(ptr_q)
  );

  for (genvar g = 0; g < NAL; g++) begin : g_slot
    rtc_alarm_slot #(.ADDR_W(ADDR_W), .DW(DW),
                     .BASE(g == 0 ? A_BASE : B_BASE)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .ptr(ptr_q), .wdata(wdata),
      .tick(sec_tick), .cur_mon(cur_mon), .cur_date(cur_date),
      .cur_hour(cur_hour), .cur_min(cur_min), .cur_sec(cur_sec),
      .hit(hit_v[g]), .rd_val(slot_rd[g]), .irq_en(en_v[g]), .fire(fire_ev[g])
    );
  end

  assign on_flag    = (ptr_q == FLAG);
  assign flag_rd_ev = rd_go && on_flag;

  rtc_alarm_flags #(.NAL(NAL)) u_flags (
    .clk(clk), .rst_n(rst_n), .fire(fire_ev), .clr(flag_rd_ev),
    .enables(en_v), .masked(on_flag), .flags(flags_q), .irq_n(irq_n)
  );

  always_comb begin
    rd_mux = '0;
    if (on_flag) rd_mux = DW'(flags_q);
    for (int i = 0; i < NAL; i++)
      if (hit_v[i]) rd_mux = slot_rd[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_go) rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_alarm_pair_chk.sv
module rtc_alarm_pair_chk #(
  parameter int ADDR_W    = 5,
  parameter int FLAG_ADDR = 15,
  parameter int TOP_ADDR  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              on_batt,
  input logic              ptr_ld,
  input logic              wr_en,
  input logic              rd_en,
  input logic              irq_n,
  input logic [ADDR_W-1:0] ptr_q,
  input logic [1:0]        flags_q,
  input logic [1:0]        fire_ev,
  input logic              flag_rd_ev
);
  a_r7_masked_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == ADDR_W'(FLAG_ADDR)) |-> irq_n);

  a_r7_fire_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ev[0] |=> flags_q[0]);

  a_r7_fire_sets_b: assert property (@(posedge clk) disable iff (!rst_n)
    fire_ev[1] |=> flags_q[1]);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd_ev && fire_ev == 2'b00) |=> (flags_q == 2'b00));

  a_r6_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |-> (fire_ev == 2'b00));

  a_r10_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    on_batt |=> $stable(ptr_q));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == ADDR_W'(TOP_ADDR) && !on_batt && !ptr_ld && (wr_en || rd_en))
    |=> (ptr_q == '0));
endmodule

bind rtc_alarm_pair rtc_alarm_pair_chk #(
  .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .TOP_ADDR(TOP_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .on_batt(on_batt),
  .ptr_ld(ptr_ld), .wr_en(wr_en), .rd_en(rd_en), .irq_n(irq_n),
  .ptr_q(ptr_q), .flags_q(flags_q), .fire_ev(fire_ev), .flag_rd_ev(flag_rd_ev)
);

// File: tb/rtc_alarm_pair_tb.sv
module rtc_alarm_pair_tb;
  logic       clk = 0, rst_n = 0, sec_tick = 0, on_batt = 0;
  logic [7:0] cur_mon = 0, cur_date = 0, cur_hour = 0, cur_min = 0, cur_sec = 0;
  logic       ptr_ld = 0, wr_en = 0, rd_en = 0;
  logic [4:0] ptr_val = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       irq_n;

  int checks = 0, failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_q = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  rtc_alarm_pair u_dut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .on_batt(on_batt),
    .cur_mon(cur_mon), .cur_date(cur_date), .cur_hour(cur_hour),
    .cur_min(cur_min), .cur_sec(cur_sec), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when a read result is due.
  always @(posedge clk) rd_q <= rd_en && !on_batt;
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  task automatic set_ptr(input logic [4:0] a);
    ptr_ld = 1; ptr_val = a; @(posedge clk); #1 ptr_ld = 0;
  endtask
  task automatic wr(input logic [7:0] d);
    wr_en = 1; wdata = d; @(posedge clk); #1 wr_en = 0;
  endtask
  task automatic rd(input logic [7:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1; @(posedge clk); #1 rd_en = 0;
  endtask
  task automatic tick();
    sec_tick = 1; @(posedge clk); #1 sec_tick = 0;
  endtask
  task automatic set_time(input logic [7:0] mo, dt, hr, mi, se);
    cur_mon = mo; cur_date = dt; cur_hour = hr; cur_min = mi; cur_sec = se;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1 irq idle after reset", 8'(irq_n), 8'h01);
    // R9: reset registers form a disabled alarm; all-zero time must not fire.
    tick();
    check("R9 disabled alarm irq", 8'(irq_n), 8'h01);
    set_ptr(5'h0F);
    rd(8'h00, "R9 R1 flags zero");
    set_ptr(5'h0A);
    rd(8'h00, "R1 alarm A byte0 zero");

    // Alarm A: full match, irq enabled, month 07 date 15 09:30:45.
    set_ptr(5'h0A);
    wr(8'h87); wr(8'h15); wr(8'h09); wr(8'h30); wr(8'h45);
    set_ptr(5'h0A);
    rd(8'h87, "R2 readback b0"); rd(8'h15, "R2 readback b1");
    rd(8'h09, "R2 readback b2"); rd(8'h30, "R2 readback b3");
    rd(8'h45, "R2 readback b4");
    // pointer now sits on 0x0F
    set_time(8'h07, 8'h15, 8'h09, 8'h30, 8'h45);
    @(posedge clk); #1;
    check("R6 no tick no irq", 8'(irq_n), 8'h01);
    tick();
    check("R7 masked on flag addr", 8'(irq_n), 8'h01);
    set_ptr(5'h00);
    check("R7 irq after pointer moves", 8'(irq_n), 8'h00);
    set_ptr(5'h0F);
    check("R7 remasked", 8'(irq_n), 8'h01);
    rd(8'h01, "R8 first flag read");
    check("R8 irq released", 8'(irq_n), 8'h01);
    set_ptr(5'h0F);
    rd(8'h00, "R8 second flag read");

    // R4: month mismatch in full-match mode.
    cur_mon = 8'h08;
    set_ptr(5'h00);
    tick();
    check("R4 month mismatch irq", 8'(irq_n), 8'h01);

    // Alarm B: code 11110, seconds 45 only.
    set_ptr(5'h14);
    wr(8'h80); wr(8'hC1); wr(8'h81); wr(8'h80); wr(8'h45);
    // R3 pointer wrapped to 0x00, irq not masked
    tick();
    check("R4 seconds mode fires", 8'(irq_n), 8'h00);
    set_ptr(5'h0F);
    rd(8'h02, "R4 R7 flag B");
    cur_sec = 8'h46;
    set_ptr(5'h00);
    tick();
    check("R4 seconds mismatch", 8'(irq_n), 8'h01);

    // R5: unlisted code 01110 on alarm B fires on every tick.
    set_ptr(5'h15);
    wr(8'h41); wr(8'h81); wr(8'h80); wr(8'h45);
    tick();
    check("R5 unlisted code fires", 8'(irq_n), 8'h00);
    set_ptr(5'h0F);
    rd(8'h02, "R5 flag B");

    // R7: enable off: flag set, irq stays high.
    set_ptr(5'h14); wr(8'h00);
    set_ptr(5'h00);
    tick();
    check("R7 disabled irq enable", 8'(irq_n), 8'h01);
    set_ptr(5'h0F);
    rd(8'h02, "R7 flag without enable");

    // R10: battery mode.
    set_ptr(5'h14); wr(8'h80);
    set_ptr(5'h00);
    on_batt = 1;
    set_ptr(5'h14); wr(8'h00);
    tick();
    check("R10 irq on battery", 8'(irq_n), 8'h00);
    on_batt = 0;
    set_ptr(5'h14);
    rd(8'h80, "R10 write ignored");
    set_ptr(5'h0F);
    rd(8'h02, "R10 flag on battery");

    // R3: wrap from 0x18 to 0x00 then walk to 0x0A.
    set_ptr(5'h18);
    rd(8'h45, "R3 top byte");
    for (int i = 0; i < 10; i++) rd(8'h00, "R2 unimplemented reads zero");
    rd(8'h87, "R3 wrapped to alarm A");

    @(posedge clk); #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule